// File: doc/BRIEF.md
# Serial Register Front End for a 12-bit DAC

This block is the digital slave side of a serial-programmed 12-bit digital-to-analog converter. A host shifts 24-bit frames in on a serial clock and data pin, most significant bit first. A rising edge on a load strobe then hands the frame to a decoder. The upper byte of the frame picks the target, and the lower 16 bits carry its value. The block holds the output code, the range and enable settings, and the readback and pass-through paths that drive the serial output. It also applies a level-sensitive clear and raises an active-low fault flag.

All pins are slow compared with the system clock. Each pin passes through a synchroniser, and edges are found in the system clock domain. The serial pins are paced entirely by the host. There is no valid/ready handshake and no back-pressure. The only form of flow control is the hold-off window that follows a control write. A load strobe that arrives inside that window is dropped, while the bits of that frame still shift in normally. Serial-out data is presented as a data bit plus an output-enable, so that a pad can build the three-state driver.

Top module: `dac_serial_regif`

## Requirements
- R1: After power-on reset the output code is 0, the range field is 0, output-enable and pass-through are off, the serial output is not driven, the hold-off flag is clear and the fault flag is high, given that both fault inputs are low.
- R2: A frame with target byte 0x01 sets the output code to payload bits [15:4], but only when the load strobe rises. Shifting without a strobe leaves the code unchanged.
- R3: Data is sampled on rising serial-clock edges, and a strobe acts on the last 24 bits shifted. Any earlier bits are discarded.
- R4: Target bytes 0x00 and any value not listed in R2, R5, R7 and R12 change no setting and no code.
- R5: A frame with target byte 0x55 sets range = payload[2:0], pass-through = payload[3] and output-enable = payload[12].
- R6: A committed control write raises the hold-off flag for BUSY_CYCLES system clocks. During that time every strobe is ignored.
- R7: A frame with target byte 0x02 selects a register with payload[1:0]: 0 selects the code as {code,4'b0000}, 1 selects the control word in the R5 layout, and 2 selects status {14'b0, over-temperature, open-circuit}. During the next frame the serial output drives 8 zero bits, then that 16-bit word, most significant bit first, changing on falling serial-clock edges.
- R8: With pass-through on, the 24-bit frame taken at each strobe is shifted out on the serial output during the following frame. A readback takes priority over pass-through.
- R9: A strobe that loads neither a readback word nor a pass-through frame turns the serial-output enable off.
- R10: While clear is high, the code is forced and data writes have no effect. In voltage ranges (range[2]=0) the forced code is 0x800 when clear-select is high and 0x000 when it is low. In current ranges (range[2]=1) the forced code is 0x000. The forced value stays after clear falls.
- R11: The fault flag goes low when over-temperature is high, or when open-circuit is high in a current range. Otherwise it is high.
- R12: A frame with target byte 0x56 returns the code and all control settings to their reset values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low power-on reset |
| sclk | input | 1 | Serial clock, idles low |
| sdin | input | 1 | Serial data in |
| latch | input | 1 | Load strobe, acts on its rising edge |
| clear | input | 1 | Active-high clear level |
| clear_sel | input | 1 | Clear value select: 1 for mid-scale, 0 for zero |
| flt_open | input | 1 | Open-circuit condition |
| flt_temp | input | 1 | Over-temperature condition |
| sdo | output | 1 | Serial data out |
| sdo_oe | output | 1 | Serial data out drive enable |
| dac_code | output | 12 | Output code |
| range_sel | output | 3 | Range setting |
| out_en | output | 1 | Output enable setting |
| daisy_en | output | 1 | Pass-through setting |
| busy | output | 1 | Hold-off window after a control write |
| fault_n | output | 1 | Active-low fault flag |

## Verification
The bench sends frames with distinct, asymmetric payloads to several targets. This shows that the code field really comes from bits [15:4] and that each control field lands in its own place. A 28-bit burst before one strobe separates a last-24-bits window from a count-from-strobe scheme. Readback is run for all three selections, and the pass-through frame is compared bit for bit, which checks both the shift-out order and the priority of the output paths. The clear tests cover both voltage settings of clear-select and a current range, plus a data write made while clear is held. A data write and a second control write are sent inside the hold-off window to show that strobes are dropped there and honoured once the window ends.

// File: rtl/dacif_pkg.sv
package dacif_pkg;

  localparam int FRAME_W   = 24;
  localparam int ADDR_W    = 8;
  localparam int PAY_W     = FRAME_W - ADDR_W;
  localparam int CODE_W    = 12;
  localparam int CODE_LSB  = PAY_W - CODE_W;
  localparam int RANGE_W   = 3;
  localparam int OE_BIT    = 12;
  localparam int DAISY_BIT = 3;

  localparam logic [ADDR_W-1:0] T_NOP   = 8'h00;
  localparam logic [ADDR_W-1:0] T_CODE  = 8'h01;
  localparam logic [ADDR_W-1:0] T_RDSEL = 8'h02;
  localparam logic [ADDR_W-1:0] T_CTRL  = 8'h55;
  localparam logic [ADDR_W-1:0] T_RESET = 8'h56;

  localparam logic [CODE_W-1:0] CODE_MID = CODE_W'(1) << (CODE_W - 1);

  typedef enum logic [1:0] {
    RD_CODE = 2'd0,
    RD_CTRL = 2'd1,
    RD_STAT = 2'd2,
    RD_NONE = 2'd3
  } rd_sel_e;

  typedef struct packed {
    logic               out_en;
    logic               daisy;
    logic [RANGE_W-1:0] range;
  } ctrl_t;

  function automatic logic is_current(input logic [RANGE_W-1:0] r);
    return r[RANGE_W-1];
  endfunction

  function automatic ctrl_t ctrl_unpack(input logic [PAY_W-1:0] p);
    ctrl_t c;
    c.out_en = p[OE_BIT];
    c.daisy  = p[DAISY_BIT];
    c.range  = p[RANGE_W-1:0];
    return c;
  endfunction

  function automatic logic [PAY_W-1:0] ctrl_pack(input ctrl_t c);
    logic [PAY_W-1:0] p;
    p = '0;
    p[OE_BIT]        = c.out_en;
    p[DAISY_BIT]     = c.daisy;
    p[RANGE_W-1:0]   = c.range;
    return p;
  endfunction

endpackage

// File: rtl/dacif_sync.sv
module dacif_sync #(
  parameter int W      = 4,
  parameter int STAGES = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d_in,
  output logic [W-1:0] d_out
);

  logic [STAGES-1:0][W-1:0] st;

  generate
    if (STAGES > 1) begin : g_chain
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st <= '0;
        else        st <= {st[STAGES-2:0], d_in};
      end
    end else begin : g_single
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st <= '0;
        else        st <= d_in;
      end
    end
  endgenerate

  assign d_out = st[STAGES-1];

endmodule

// File: rtl/dacif_shift.sv
module dacif_shift
  import dacif_pkg::*;
(
  input  logic               clk,
  input  logic               rst_n,
  input  logic               sck_rise,
  input  logic               sck_fall,
  input  logic               sdi,
  input  logic               ld,
  input  logic               rd_load,
  input  logic [PAY_W-1:0]   rd_word,
  input  logic               pass_load,
  output logic [FRAME_W-1:0] frame,
  output logic               sdo_d,
  output logic               sdo_oe
);

  logic [FRAME_W-1:0] in_q;
  logic [FRAME_W-1:0] out_q;
  logic               oe_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        in_q <= '0;
    else if (sck_rise) in_q <= {in_q[FRAME_W-2:0], sdi};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      out_q <= '0;
      oe_q  <= 1'b0;
    end else if (ld) begin
      if (rd_load) begin
        out_q <= {{ADDR_W{1'b0}}, rd_word};
        oe_q  <= 1'b1;
      end else if (pass_load) begin
        out_q <= in_q;
        oe_q  <= 1'b1;
      end else begin
        out_q <= '0;
        oe_q  <= 1'b0;
      end
    end else if (sck_fall && oe_q) begin
      out_q <= {out_q[FRAME_W-2:0], 1'b0};
    end
  end

  assign frame  = in_q;
  assign sdo_d  = oe_q & out_q[FRAME_W-1];
  assign sdo_oe = oe_q;

  p_sdo_float_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (ld && !rd_load && !pass_load) |=> !sdo_oe);

  p_rd_prefix_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (ld && rd_load) |=> (sdo_oe && out_q[FRAME_W-1 -: ADDR_W] == '0));

  p_pass_copy_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (ld && !rd_load && pass_load) |=> (out_q == $past(in_q)));

  p_in_sample_r3: assert property (@(posedge clk) disable iff (!rst_n)
    sck_rise |=> (in_q[0] == $past(sdi)));

endmodule

// File: rtl/dacif_regs.sv
module dacif_regs
  import dacif_pkg::*;
#(
  parameter int BUSY_CYCLES = 500
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               commit,
  input  logic [FRAME_W-1:0] frame,
  input  logic               clr,
  input  logic               clr_mid,
  input  logic               flt_open,
  input  logic               flt_temp,
  output logic [CODE_W-1:0]  code,
  output ctrl_t              ctrl,
  output logic               busy,
  output logic               rd_load,
  output logic [PAY_W-1:0]   rd_word,
  output logic               pass_load,
  output logic               fault_n
);

  localparam int CNT_W = $clog2(BUSY_CYCLES + 1);

  logic [ADDR_W-1:0] tgt;
  logic [PAY_W-1:0]  pay;
  logic              accept;
  logic              wr_code, wr_ctrl, wr_rst;
  logic [CNT_W-1:0]  cnt_q;
  logic [CODE_W-1:0] code_q;
  logic [CODE_W-1:0] clr_val;
  ctrl_t             ctrl_q;
  logic              fault_n_q;

  assign tgt     = frame[FRAME_W-1 -: ADDR_W];
  assign pay     = frame[PAY_W-1:0];
  assign busy    = (cnt_q != '0);
  assign accept  = commit & ~busy;
  assign wr_code = accept && (tgt == T_CODE);
  assign wr_ctrl = accept && (tgt == T_CTRL);
  assign wr_rst  = accept && (tgt == T_RESET);
  assign rd_load = accept && (tgt == T_RDSEL);

  assign clr_val = (is_current(ctrl_q.range) || !clr_mid) ? '0 : CODE_MID;

  always_comb begin
    unique case (rd_sel_e'(pay[1:0]))
      RD_CODE: rd_word = {code_q, {CODE_LSB{1'b0}}};
      RD_CTRL: rd_word = ctrl_pack(ctrl_q);
      RD_STAT: rd_word = {{(PAY_W-2){1'b0}}, flt_temp, flt_open};
      default: rd_word = '0;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       cnt_q <= '0;
    else if (wr_ctrl) cnt_q <= CNT_W'(BUSY_CYCLES);
    else if (busy)    cnt_q <= cnt_q - CNT_W'(1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       ctrl_q <= '0;
    else if (wr_rst)  ctrl_q <= '0;
    else if (wr_ctrl) ctrl_q <= ctrl_unpack(pay);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       code_q <= '0;
    else if (clr)     code_q <= clr_val;
    else if (wr_rst)  code_q <= '0;
    else if (wr_code) code_q <= pay[PAY_W-1 -: CODE_W];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) fault_n_q <= 1'b1;
    else        fault_n_q <= ~((is_current(ctrl_q.range) & flt_open) | flt_temp);
  end

  assign code      = code_q;
  assign ctrl      = ctrl_q;
  assign pass_load = ctrl_q.daisy;
  assign fault_n   = fault_n_q;

  p_busy_drop_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && commit && !clr) |=> ($stable(code_q) && $stable(ctrl_q)));

  p_busy_start_r6: assert property (@(posedge clk) disable iff (!rst_n)
    wr_ctrl |=> busy);

  p_code_idle_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (!commit && !clr) |=> $stable(code_q));

  p_clear_force_r10: assert property (@(posedge clk) disable iff (!rst_n)
    clr |=> (code_q == ((is_current($past(ctrl_q.range)) || !$past(clr_mid))
                        ? '0 : CODE_MID)));

  p_temp_fault_r11: assert property (@(posedge clk) disable iff (!rst_n)
    flt_temp |=> !fault_n);

  p_reset_cmd_r12: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_rst && !clr) |=> (code_q == '0 && ctrl_q == '0));

endmodule

// File: rtl/dac_serial_regif.sv
module dac_serial_regif
  import dacif_pkg::*;
#(
  parameter int BUSY_CYCLES = 500,
  parameter int SYNC_STAGES = 2
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               sclk,
  input  logic               sdin,
  input  logic               latch,
  input  logic               clear,
  input  logic               clear_sel,
  input  logic               flt_open,
  input  logic               flt_temp,
  output logic               sdo,
  output logic               sdo_oe,
  output logic [CODE_W-1:0]  dac_code,
  output logic [RANGE_W-1:0] range_sel,
  output logic               out_en,
  output logic               daisy_en,
  output logic               busy,
  output logic               fault_n
);

  localparam int N_SYNC = 7;
  localparam int I_SCK  = 0;
  localparam int I_SDI  = 1;
  localparam int I_LAT  = 2;
  localparam int I_CLR  = 3;
  localparam int I_CSEL = 4;
  localparam int I_OPEN = 5;
  localparam int I_TEMP = 6;

  logic [N_SYNC-1:0]  raw;
  logic [N_SYNC-1:0]  lvl;
  logic               sck_q, lat_q;
  logic               sck_rise, sck_fall, lat_rise;
  logic [FRAME_W-1:0] frame;
  logic               rd_load, pass_load;
  logic [PAY_W-1:0]   rd_word;
  ctrl_t              ctrl;

  assign raw = {flt_temp, flt_open, clear_sel, clear, latch, sdin, sclk};

  dacif_sync #(
    .W      (N_SYNC),
    .STAGES (SYNC_STAGES)
  ) u_sync (
    .clk   (clk),
    .rst_n (rst_n),
    .d_in  (raw),
    .d_out (lvl)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sck_q <= 1'b0;
      lat_q <= 1'b0;
    end else begin
      sck_q <= lvl[I_SCK];
      lat_q <= lvl[I_LAT];
    end
  end

  assign sck_rise = lvl[I_SCK] & ~sck_q;
  assign sck_fall = ~lvl[I_SCK] & sck_q;
  assign lat_rise = lvl[I_LAT] & ~lat_q;

  dacif_shift u_shift (
    .clk       (clk),
    .rst_n     (rst_n),
    .sck_rise  (sck_rise),
    .sck_fall  (sck_fall),
    .sdi       (lvl[I_SDI]),
    .ld        (lat_rise),
    .rd_load   (rd_load),
    .rd_word   (rd_word),
    .pass_load (pass_load),
    .frame     (frame),
    .sdo_d     (sdo),
    .sdo_oe    (sdo_oe)
  );

  dacif_regs #(
    .BUSY_CYCLES (BUSY_CYCLES)
  ) u_regs (
    .clk       (clk),
    .rst_n     (rst_n),
    .commit    (lat_rise),
    .frame     (frame),
    .clr       (lvl[I_CLR]),
    .clr_mid   (lvl[I_CSEL]),
    .flt_open  (lvl[I_OPEN]),
    .flt_temp  (lvl[I_TEMP]),
    .code      (dac_code),
    .ctrl      (ctrl),
    .busy      (busy),
    .rd_load   (rd_load),
    .rd_word   (rd_word),
    .pass_load (pass_load),
    .fault_n   (fault_n)
  );

  assign range_sel = ctrl.range;
  assign out_en    = ctrl.out_en;
  assign daisy_en  = ctrl.daisy;

  p_sdo_quiet_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !sdo_oe |-> !sdo);

endmodule

// File: tb/test_dac_serial_regif.sv
module test_dac_serial_regif;

  localparam int BUSY = 500;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        sclk = 1'b0, sdin = 1'b0, latch = 1'b0, clear = 1'b0;
  logic        clear_sel = 1'b0, flt_open = 1'b0, flt_temp = 1'b0;
  logic        sdo, sdo_oe, out_en, daisy_en, busy, fault_n;
  logic [11:0] dac_code;
  logic [2:0]  range_sel;
  int          n_cmp = 0;
  int          n_bad = 0;
  bit          done = 1'b0;

  always #5 clk = ~clk;

  dac_serial_regif #(.BUSY_CYCLES(BUSY), .SYNC_STAGES(2)) i_dac_serial_regif (
    .clk(clk), .rst_n(rst_n), .sclk(sclk), .sdin(sdin), .latch(latch),
    .clear(clear), .clear_sel(clear_sel), .flt_open(flt_open), .flt_temp(flt_temp),
    .sdo(sdo), .sdo_oe(sdo_oe), .dac_code(dac_code), .range_sel(range_sel),
    .out_en(out_en), .daisy_en(daisy_en), .busy(busy), .fault_n(fault_n)
  );

  task automatic chk(input string req, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  task automatic ticks(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic xfer(input logic [31:0] w, input int n, output logic [31:0] got);
    got = '0;
    for (int i = n - 1; i >= 0; i--) begin
      sdin = w[i];
      ticks(4);
      got[i] = sdo;
      sclk = 1'b1;
      ticks(4);
      sclk = 1'b0;
    end
    ticks(4);
  endtask

  task automatic strobe;
    latch = 1'b1;
    ticks(4);
    latch = 1'b0;
    ticks(6);
  endtask

  task automatic frame_tx(input logic [7:0] t, input logic [15:0] p,
                          output logic [31:0] got);
    xfer({8'h00, t, p}, 24, got);
    strobe();
  endtask

  task automatic t_reset;
    chk("R1", "code", 32'(dac_code), 32'h0);
    chk("R1", "range", 32'(range_sel), 32'h0);
    chk("R1", "out_en", 32'(out_en), 32'h0);
    chk("R1", "daisy", 32'(daisy_en), 32'h0);
    chk("R1", "sdo_oe", 32'(sdo_oe), 32'h0);
    chk("R1", "busy", 32'(busy), 32'h0);
    chk("R1", "fault_n", 32'(fault_n), 32'h1);
  endtask

  task automatic t_code_write;
    logic [31:0] g;
    xfer({8'h00, 8'h01, 16'hABC5}, 24, g);
    chk("R2", "code before strobe", 32'(dac_code), 32'h0);
    strobe();
    chk("R2", "code after strobe", 32'(dac_code), 32'hABC);
    frame_tx(8'h01, 16'h0010, g);
    chk("R2", "code second write", 32'(dac_code), 32'h001);
  endtask

  task automatic t_frame_window;
    logic [31:0] g;
    xfer({4'h0, 4'hB, 8'h01, 16'h3F2A}, 28, g);
    strobe();
    chk("R3", "last 24 bits", 32'(dac_code), 32'h3F2);
  endtask

  task automatic t_ignored_targets;
    logic [31:0] g;
    frame_tx(8'h00, 16'hFFFF, g);
    chk("R4", "nop code", 32'(dac_code), 32'h3F2);
    chk("R4", "nop range", 32'(range_sel), 32'h0);
    frame_tx(8'h7A, 16'hFFF0, g);
    chk("R4", "unknown code", 32'(dac_code), 32'h3F2);
    chk("R4", "unknown out_en", 32'(out_en), 32'h0);
  endtask

  task automatic t_control_busy;
    logic [31:0] g;
    frame_tx(8'h55, 16'h1006, g);
    chk("R5", "range", 32'(range_sel), 32'h6);
    chk("R5", "out_en", 32'(out_en), 32'h1);
    chk("R5", "daisy", 32'(daisy_en), 32'h0);
    chk("R6", "busy raised", 32'(busy), 32'h1);
    frame_tx(8'h01, 16'h5550, g);
    chk("R6", "code write dropped", 32'(dac_code), 32'h3F2);
    frame_tx(8'h55, 16'h0000, g);
    chk("R6", "ctrl write dropped", 32'(range_sel), 32'h6);
    ticks(BUSY);
    chk("R6", "busy released", 32'(busy), 32'h0);
    frame_tx(8'h01, 16'h5550, g);
    chk("R6", "code write after window", 32'(dac_code), 32'h555);
  endtask

  task automatic t_readback;
    logic [31:0] g;
    frame_tx(8'h02, 16'h0001, g);
    chk("R7", "sdo_oe after select", 32'(sdo_oe), 32'h1);
    frame_tx(8'h00, 16'h0000, g);
    chk("R7", "ctrl readback", g & 32'hFFFFFF, 32'h001006);
    chk("R9", "float after plain strobe", 32'(sdo_oe), 32'h0);
    frame_tx(8'h02, 16'h0000, g);
    frame_tx(8'h00, 16'h0000, g);
    chk("R7", "code readback", g & 32'hFFFFFF, 32'h005550);
    flt_open = 1'b1;
    ticks(6);
    frame_tx(8'h02, 16'h0002, g);
    frame_tx(8'h00, 16'h0000, g);
    chk("R7", "status readback", g & 32'hFFFFFF, 32'h000001);
  endtask

  task automatic t_fault;
    logic [31:0] g;
    chk("R11", "open in current range", 32'(fault_n), 32'h0);
    frame_tx(8'h55, 16'h1001, g);
    ticks(6);
    chk("R11", "open in voltage range", 32'(fault_n), 32'h1);
    ticks(BUSY);
    flt_temp = 1'b1;
    ticks(6);
    chk("R11", "over-temperature", 32'(fault_n), 32'h0);
    flt_temp = 1'b0;
    flt_open = 1'b0;
    ticks(6);
    chk("R11", "no cause", 32'(fault_n), 32'h1);
  endtask

  task automatic t_clear;
    logic [31:0] g;
    clear_sel = 1'b1;
    clear = 1'b1;
    ticks(6);
    chk("R10", "mid-scale voltage", 32'(dac_code), 32'h800);
    frame_tx(8'h01, 16'h1230, g);
    chk("R10", "write under clear", 32'(dac_code), 32'h800);
    clear_sel = 1'b0;
    ticks(6);
    chk("R10", "zero-scale voltage", 32'(dac_code), 32'h000);
    clear = 1'b0;
    ticks(6);
    chk("R10", "value kept after clear", 32'(dac_code), 32'h000);
    frame_tx(8'h55, 16'h1005, g);
    ticks(BUSY);
    frame_tx(8'h01, 16'h7770, g);
    clear_sel = 1'b1;
    clear = 1'b1;
    ticks(6);
    chk("R10", "current range bottom", 32'(dac_code), 32'h000);
    clear = 1'b0;
    clear_sel = 1'b0;
    ticks(6);
  endtask

  task automatic t_daisy;
    logic [31:0] g;
    frame_tx(8'h55, 16'h1009, g);
    ticks(BUSY);
    chk("R5", "daisy bit", 32'(daisy_en), 32'h1);
    frame_tx(8'h01, 16'h2460, g);
    chk("R8", "sdo_oe in pass-through", 32'(sdo_oe), 32'h1);
    chk("R8", "code written", 32'(dac_code), 32'h246);
    frame_tx(8'h00, 16'h0000, g);
    chk("R8", "echoed frame", g & 32'hFFFFFF, 32'h012460);
  endtask

  task automatic t_reset_cmd;
    logic [31:0] g;
    frame_tx(8'h56, 16'h0000, g);
    chk("R12", "code", 32'(dac_code), 32'h0);
    chk("R12", "range", 32'(range_sel), 32'h0);
    chk("R12", "out_en", 32'(out_en), 32'h0);
    chk("R12", "daisy", 32'(daisy_en), 32'h0);
    frame_tx(8'h00, 16'h0000, g);
    chk("R9", "float once pass-through off", 32'(sdo_oe), 32'h0);
  endtask

  initial begin
    ticks(5);
    rst_n = 1'b1;
    ticks(5);
    t_reset();
    t_code_write();
    t_frame_window();
    t_ignored_targets();
    t_control_busy();
    t_readback();
    t_fault();
    t_clear();
    t_daisy();
    t_reset_cmd();
    if (!done) begin
      done = 1'b1;
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      n_cmp++;
      n_bad++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

endmodule